// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a function return will jump before the return executes. The fetch unit sends each branch into it once it has been decoded. The branch arrives as a kind code, together with its PC and a flag that says whether its source register is the link register. A call pushes the address of the following instruction onto a small circular stack. A return pops the newest entry and offers it as the predicted target in the same cycle. Any other register-indirect branch leaves the stack untouched and raises a strobe, which hands the branch to a separate indirect-target predictor.

A mode input selects how a plain branch-to-register is classified. With the mode off, only a branch carrying the explicit return hint counts as a return. With the mode on, any branch-to-register whose source is the link register also counts as a return. Software can rewrite the link register before returning. For this reason a resolve port takes the real target, raises a mispredict flag when it differs from the last prediction, and keeps hit and miss tallies in saturating counters.

Top module: `ras_predictor`

## Requirements
- R1: The stack has 4 entries in a circular buffer. A fifth push without a pop overwrites the oldest entry with no stall and no error, so the four pops that follow return the newest four addresses, newest first.
- R2: A branch of kind 1 (call) pushes its PC plus 4.
- R3: A branch of kind 2 (register branch with return hint) pops. In the same cycle `predValid` is 1, and `predTarget` is the newest entry.
- R4: With `inferMode` at 0, a branch of kind 3 (plain register branch) does not touch the stack, even when its source is the link register. It raises `indirStrobe` and gives no prediction.
- R5: With `inferMode` at 1, a kind 3 branch with `brSrcIsLink` at 1 is handled as a return: it pops and predicts.
- R6: A kind 3 branch that is not classified as a return raises `indirStrobe` for that cycle, keeps `predValid` at 0, and leaves the stack unchanged.
- R7: A pop on an empty stack still outputs the stale entry under the pointer, with `predLive` at 0, and the pointer wraps modulo 4. `predLive` is 1 only when the entry was pushed and has not been popped since.
- R8: While `resValid` is 1, `mispredict` is 1 exactly when `resTarget` differs from the last predicted target.
- R9: Each resolve increments `hitCount` (target matched) or `missCount` (target differed) on the next edge. Both counters are 16 bits wide and hold at 0xFFFF.
- R10: A synchronous reset clears the pointer, the occupancy count, all valid bits, the stored addresses, the last prediction and both counters.
- R11: A branch of kind 0 (no register branch) and a cycle with `brValid` at 0 leave the stack and all strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inferMode | input | 1 | 1: a link-register branch without the hint counts as a return |
| brValid | input | 1 | A decoded branch is present |
| brKind | input | 2 | 0 none, 1 call, 2 return-hinted register branch, 3 plain register branch |
| brSrcIsLink | input | 1 | The source register of the branch is the link register |
| brPc | input | 32 | PC of the branch |
| resValid | input | 1 | A resolved return target is present |
| resTarget | input | 32 | Actual target of the resolved return |
| predValid | output | 1 | A return was popped in this cycle |
| predTarget | output | 32 | Predicted return target |
| predLive | output | 1 | The predicted entry was live |
| indirStrobe | output | 1 | The branch goes to the indirect-target predictor |
| mispredict | output | 1 | The resolved target differs from the last prediction |
| hitCount | output | 16 | Saturating count of correct predictions |
| missCount | output | 16 | Saturating count of mispredictions |

## Verification
The assertions assume that `brKind` is never unknown while `brValid` is high, and that a resolve refers to the most recent pop. The bench keeps to both assumptions. It drives every branch with a defined kind, and it issues each resolve in its own cycle after the return it checks. It never overlaps a resolve with a new pop. Call and return cannot collide, because a single branch port carries one kind per cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    BR_NONE    = 2'd0,
    BR_CALL    = 2'd1,
    BR_RETHINT = 2'd2,
    BR_REG     = 2'd3
  } brKind_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic indir;
  } rasStrobe_t;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inferMode,
  input  logic                 brValid,
  input  logic [1:0]           brKind,
  input  logic                 brSrcIsLink,
  output ras_pkg::rasStrobe_t  strobe,
  output logic [PTR_W-1:0]     wrIdx,
  output logic [PTR_W-1:0]     rdIdx
);
  import ras_pkg::*;

  logic [PTR_W-1:0] topPtr;
  logic [OCC_W-1:0] occ;
  logic isCall, isRet, isIndir, linkRet;

  // Classifier: a plain register branch from the link register counts as a
  // return only when the inferred mode is on (R4, R5).
  always_comb begin
    linkRet = inferMode && brSrcIsLink;
    isCall  = brValid && (brKind == BR_CALL);
    isRet   = brValid && ((brKind == BR_RETHINT) || ((brKind == BR_REG) && linkRet));
    isIndir = brValid && (brKind == BR_REG) && !linkRet;
    strobe.push  = isCall;
    strobe.pop   = isRet;
    strobe.indir = isIndir;
  end

  assign rdIdx = topPtr;
  assign wrIdx = topPtr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr <= '0;
      occ    <= '0;
    end else if (strobe.push) begin
      topPtr <= wrIdx;                                  // wraps modulo DEPTH
      if (occ != OCC_W'(DEPTH)) occ <= occ + OCC_W'(1);  // R1: silent overwrite
    end else if (strobe.pop) begin
      topPtr <= topPtr - PTR_W'(1);                     // R7: wraps even when empty
      if (occ != '0) occ <= occ - OCC_W'(1);
    end
  end

  p_kind_known_r11: assert property (@(posedge clk) disable iff (rst)
    brValid |-> !$isunknown(brKind));
  p_push_move_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> topPtr == $past(topPtr) + PTR_W'(1));
  p_pop_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |=> topPtr == $past(topPtr) - PTR_W'(1));
  p_occ_bound_r1: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
  p_plain_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (brValid && brKind == BR_REG && !inferMode) |=> $stable(topPtr));
  p_idle_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (!brValid || brKind == BR_NONE) |=> ($stable(topPtr) && $stable(occ)));
endmodule

// File: rtl/ras_dpath.sv
module ras_dpath #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  ras_pkg::rasStrobe_t strobe,
  input  logic [PTR_W-1:0]    wrIdx,
  input  logic [PTR_W-1:0]    rdIdx,
  input  logic [ADDR_W-1:0]   brPc,
  input  logic                resValid,
  input  logic [ADDR_W-1:0]   resTarget,
  output logic [ADDR_W-1:0]   predTarget,
  output logic                predLive,
  output logic                mispredict,
  output logic [CNT_W-1:0]    hitCount,
  output logic [CNT_W-1:0]    missCount
);
  logic [ADDR_W-1:0] memArr   [DEPTH];
  logic [DEPTH-1:0]  validVec;
  logic [ADDR_W-1:0] lastPred;
  logic [ADDR_W-1:0] pushData;

  assign pushData   = brPc + ADDR_W'(STEP);
  assign predTarget = memArr[rdIdx];
  assign predLive   = validVec[rdIdx];
  assign mispredict = resValid && (resTarget != lastPred);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
      validVec <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.push && wrIdx == PTR_W'(i)) begin
          memArr[i]   <= pushData;
          validVec[i] <= 1'b1;
        end else if (strobe.pop && rdIdx == PTR_W'(i)) begin
          validVec[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lastPred <= '0;
    else if (strobe.pop) lastPred <= predTarget;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (resValid) begin
      if (mispredict) begin
        if (missCount != CNT_MAX) missCount <= missCount + CNT_W'(1);
      end else begin
        if (hitCount != CNT_MAX) hitCount <= hitCount + CNT_W'(1);
      end
    end
  end

  p_push_store_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> (memArr[$past(wrIdx)] == $past(brPc) + ADDR_W'(STEP)) && validVec[$past(wrIdx)]);
  p_pop_clear_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |=> !validVec[$past(rdIdx)]);
  p_miss_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (missCount == CNT_MAX) |=> (missCount == CNT_MAX));
  p_hit_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (hitCount == CNT_MAX) |=> (hitCount == CNT_MAX));
  p_miss_step_r8: assert property (@(posedge clk) disable iff (rst)
    (resValid && mispredict && missCount != CNT_MAX) |=> missCount == $past(missCount) + CNT_W'(1));
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inferMode,
  input  logic              brValid,
  input  logic [1:0]        brKind,
  input  logic              brSrcIsLink,
  input  logic [ADDR_W-1:0] brPc,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resTarget,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predLive,
  output logic              indirStrobe,
  output logic              mispredict,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  ras_pkg::rasStrobe_t strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inferMode(inferMode), .brValid(brValid),
    .brKind(brKind), .brSrcIsLink(brSrcIsLink),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  ras_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .brPc(brPc), .resValid(resValid), .resTarget(resTarget),
    .predTarget(predTarget), .predLive(predLive), .mispredict(mispredict),
    .hitCount(hitCount), .missCount(missCount)
  );

  assign predValid   = strobe.pop;
  assign indirStrobe = strobe.indir;

  p_pred_indir_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(predValid && indirStrobe));
endmodule

// File: tb/ras_predictor_bench.sv
module ras_predictor_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 12;

  logic clk = 1'b0;
  logic rst, inferMode, brValid, brSrcIsLink, resValid;
  logic [1:0] brKind;
  logic [31:0] brPc, resTarget, predTarget;
  logic predValid, predLive, indirStrobe, mispredict;
  logic [15:0] hitCount, missCount;
  int applied = 0;
  int failed  = 0;

  always #(CLK_P/2) clk = ~clk;

  ras_predictor u_ras_predictor (
    .clk(clk), .rst(rst), .inferMode(inferMode), .brValid(brValid),
    .brKind(brKind), .brSrcIsLink(brSrcIsLink), .brPc(brPc),
    .resValid(resValid), .resTarget(resTarget), .predValid(predValid),
    .predTarget(predTarget), .predLive(predLive), .indirStrobe(indirStrobe),
    .mispredict(mispredict), .hitCount(hitCount), .missCount(missCount)
  );

  // {kind, link, infer, pc, expPredValid, expTarget, expLive, expIndir}
  localparam logic [70:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // R2 push 0x104
    {2'd1, 1'b0, 1'b0, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0}, // R2 push 0x204
    {2'd2, 1'b0, 1'b0, 32'h0,   1'b1, 32'h204, 1'b1, 1'b0}, // R3 hinted return
    {2'd3, 1'b1, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1}, // R4 plain link branch
    {2'd3, 1'b1, 1'b1, 32'h0,   1'b1, 32'h104, 1'b1, 1'b0}, // R5 inferred return
    {2'd3, 1'b0, 1'b1, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1}, // R6 other indirect
    {2'd2, 1'b0, 1'b0, 32'h0,   1'b1, 32'h0,   1'b0, 1'b0}, // R7 empty pop, slot 0
    {2'd1, 1'b0, 1'b0, 32'h300, 1'b0, 32'h0,   1'b0, 1'b0}, // R7 wrapped ptr, push
    {2'd2, 1'b0, 1'b0, 32'h0,   1'b1, 32'h304, 1'b1, 1'b0}, // R3
    {2'd2, 1'b0, 1'b0, 32'h0,   1'b1, 32'h0,   1'b0, 1'b0}, // R7 empty, slot 3
    {2'd0, 1'b1, 1'b1, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0}, // R11 no-op kind
    {2'd2, 1'b0, 1'b0, 32'h0,   1'b1, 32'h204, 1'b0, 1'b0}  // R11 stale slot 2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic lk, input logic inf,
                       input logic [31:0] pc, input logic rv, input logic [31:0] rt);
    @(negedge clk);
    brValid = (k != 2'd0) || lk; brKind = k; brSrcIsLink = lk;
    inferMode = inf; brPc = pc; resValid = rv; resTarget = rt;
    #1;
  endtask

  task automatic idle();
    drive(2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; brValid = 1'b0; resValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    rst = 1'b1; brValid = 0; brKind = 0; brSrcIsLink = 0; inferMode = 0;
    brPc = 0; resValid = 0; resTarget = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    idle();
    chk("R10 reset predValid", {31'd0, predValid}, 32'd0);
    chk("R10 reset hitCount", {16'd0, hitCount}, 32'd0);
    chk("R10 reset missCount", {16'd0, missCount}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][70:69], VEC[v][68], VEC[v][67], VEC[v][66:35], 1'b0, 32'h0);
      chk($sformatf("R3 predValid vec %0d", v), {31'd0, predValid}, {31'd0, VEC[v][34]});
      chk($sformatf("R6 indirStrobe vec %0d", v), {31'd0, indirStrobe}, {31'd0, VEC[v][0]});
      if (VEC[v][34]) begin
        chk($sformatf("R3 target vec %0d", v), predTarget, VEC[v][33:2]);
        chk($sformatf("R7 live vec %0d", v), {31'd0, predLive}, {31'd0, VEC[v][1]});
      end
    end

    // R8: correct prediction, then link register rewritten
    doReset();
    drive(2'd1, 1'b0, 1'b0, 32'h500, 1'b0, 32'h0);
    drive(2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    drive(2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h504);
    chk("R8 no mispredict on match", {31'd0, mispredict}, 32'd0);
    idle();
    chk("R9 hitCount after match", {16'd0, hitCount}, 32'd1);
    drive(2'd1, 1'b0, 1'b0, 32'h600, 1'b0, 32'h0);
    drive(2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    drive(2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h700);
    chk("R8 mispredict on rewritten link", {31'd0, mispredict}, 32'd1);
    idle();
    chk("R9 missCount after miss", {16'd0, missCount}, 32'd1);

    // R1: five pushes, oldest overwritten
    doReset();
    for (int i = 1; i <= 5; i++) drive(2'd1, 1'b0, 1'b0, 32'(i * 16), 1'b0, 32'h0);
    for (int i = 5; i >= 2; i--) begin
      drive(2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
      chk($sformatf("R1 pop target %0d", i), predTarget, 32'(i * 16 + 4));
      chk($sformatf("R1 pop live %0d", i), {31'd0, predLive}, 32'd1);
    end
    drive(2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R1 fifth pop stale target", predTarget, 32'h54);
    chk("R7 fifth pop not live", {31'd0, predLive}, 32'd0);

    // R10: reset drops live entries
    drive(2'd1, 1'b0, 1'b0, 32'h800, 1'b0, 32'h0);
    doReset();
    drive(2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R10 pop after reset not live", {31'd0, predLive}, 32'd0);
    chk("R10 pop after reset target", predTarget, 32'h0);

    // R9: miss counter saturates
    drive(2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 32'hdead);
    repeat (65540) @(posedge clk);
    idle();
    chk("R9 missCount saturated", {16'd0, missCount}, 32'h0000ffff);
    chk("R9 hitCount untouched", {16'd0, hitCount}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule